// File: doc/BRIEF.md
# PBKDF2-HMAC-SHA1 candidate checker

This block decides whether one password candidate reproduces a known PBKDF2-HMAC-SHA1 derived key. The host hashes the padded candidate key once with each HMAC pad and hands over the two 160-bit chaining values. It also supplies the salt, the iteration count, the derived-key length in bits and the target key. After a one-cycle `start`, the block runs every HMAC invocation of a key block as two compressions, each starting from the supplied chaining values. It folds the iteration results together and compares each finished key block with its slice of the target.

Key blocks are produced one after another. Work ends at the first block that differs from the target, so a wrong candidate normally costs a single block. A single SHA1 compression unit does one round per clock and serves both the inner and the outer hash. When the job ends, `done` pulses. `match` and the count of key blocks actually built then stay valid until the next job is accepted.

Top module: `pbkdf2Checker`

## Requirements
- R1: The first HMAC message of key block n is the salt (`saltLen` bytes, 0 to SALT_BYTES, salt byte 0 in the most significant byte of `salt`) followed by n as a 32-bit big-endian integer, with n starting at 1. Salt bytes beyond `saltLen` have no effect.
- R2: Each later HMAC message is the previous 20-byte HMAC result. The key block is the XOR of all iteration results.
- R3: An `iterCount` of 0 gives the same outcome as an `iterCount` of 1.
- R4: The job covers ceil(`dkLen`/160) key blocks, compared in index order against the target. The target's first derived bit is `targetKey[DK_BITS-1]`. The job stops after the first mismatching block. `blocksDone` reports how many blocks were computed, never exceeds MAX_BLOCKS, and steps up by one at a time.
- R5: In a block shorter than 160 bits, only its leading bits are compared. Target bits at derived positions at or beyond `dkLen` have no effect.
- R6: `done` is high for exactly one cycle per job. `match` and `blocksDone` hold their values from that pulse until the next accepted `start`. `match` is high only when every computed block matched.
- R7: A `start` that arrives while a job is running is ignored: the running job finishes with its own result, and no extra `done` follows.
- R8: After reset, `done`, `match` and `blocksDone` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a job; sampled only when idle |
| innerMid | input | 160 | SHA1 state after the key XOR inner-pad block |
| outerMid | input | 160 | SHA1 state after the key XOR outer-pad block |
| salt | input | SALT_BYTES*8 | Salt bytes, first byte most significant |
| saltLen | input | $clog2(SALT_BYTES+1) | Salt length in bytes |
| iterCount | input | 32 | Iteration count c (0 acts as 1) |
| dkLen | input | $clog2(DK_BITS+1) | Derived-key length in bits, 1 to DK_BITS |
| targetKey | input | DK_BITS | Target derived key, first bit most significant |
| done | output | 1 | One-cycle completion pulse |
| match | output | 1 | Candidate reproduced the target |
| blocksDone | output | $clog2(MAX_BLOCKS+1) | Key blocks computed in the last job |

## Verification
The known-answer inputs for one and two iterations pin down the message layout, the padding and the chaining, independently of the bench's own reference model. The table then varies the iteration count (including 0), the salt length (empty, short and full width) and the key length (one full block, a truncated block, and two blocks). The target is either exact or has one bit flipped. A flip inside block one, a flip inside block two, and a flip past the key length tell early rejection, late rejection and ignored target bits apart through `match` together with `blocksDone`. Separate runs check that results hold after `done` and that a second `start` during a job changes nothing.

// File: rtl/pbkdfPkg.sv
package pbkdfPkg;

  typedef struct packed {
    logic loadJob;     // capture job inputs, clear results
    logic coreGo;      // launch one compression
    logic selOuter;    // launch uses outer chaining value
    logic takeInner;   // store inner digest
    logic takeOuter;   // store iteration result, fold into key block
    logic closeBlock;  // key block finished, advance index
    logic finish;      // publish result
  } ctrlStrobe_t;

  function automatic logic [31:0] rotl(input logic [31:0] x, input int n);
    return (x << n) | (x >> (32 - n));
  endfunction

  function automatic logic [31:0] roundF(input logic [6:0] t, input logic [31:0] b,
                                         input logic [31:0] c, input logic [31:0] d);
    if (t < 7'd20)      return d ^ (b & (c ^ d));
    else if (t < 7'd40) return b ^ c ^ d;
    else if (t < 7'd60) return (b & c) | (d & (b | c));
    else                return b ^ c ^ d;
  endfunction

  function automatic logic [31:0] roundK(input logic [6:0] t);
    if (t < 7'd20)      return 32'h5A827999;
    else if (t < 7'd40) return 32'h6ED9EBA1;
    else if (t < 7'd60) return 32'h8F1BBCDC;
    else                return 32'hCA62C1D6;
  endfunction

endpackage

// File: rtl/sha1Core.sv
module sha1Core
  import pbkdfPkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         go,
  input  logic [159:0] chainIn,
  input  logic [511:0] blockIn,
  output logic         ready,
  output logic [159:0] digest
);
  localparam int ROUNDS = 80;

  logic [31:0]  a, b, c, d, e;
  logic [159:0] chainQ;
  logic [31:0]  wq [16];
  logic [6:0]   round;
  logic         running;
  logic [31:0]  wt, tmp;

  always_comb begin
    wt  = (round < 7'd16) ? wq[0] : rotl(wq[13] ^ wq[8] ^ wq[2] ^ wq[0], 1);
    tmp = rotl(a, 5) + roundF(round, b, c, d) + e + wt + roundK(round);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      {a, b, c, d, e} <= '0;
      chainQ  <= '0;
      round   <= '0;
      running <= 1'b0;
      ready   <= 1'b0;
      for (int i = 0; i < 16; i++) wq[i] <= '0;
    end else begin
      ready <= 1'b0;
      if (go && !running) begin
        chainQ          <= chainIn;
        {a, b, c, d, e} <= chainIn;
        for (int i = 0; i < 16; i++) wq[i] <= blockIn[511-32*i -: 32];
        round   <= '0;
        running <= 1'b1;
      end else if (running) begin
        a <= tmp;
        b <= a;
        c <= rotl(b, 30);
        d <= c;
        e <= d;
        for (int i = 0; i < 15; i++) wq[i] <= wq[i+1];
        wq[15] <= wt;
        round  <= round + 7'd1;
        if (round == 7'(ROUNDS - 1)) begin
          running <= 1'b0;
          ready   <= 1'b1;
        end
      end
    end
  end

  assign digest = {chainQ[159:128] + a, chainQ[127:96] + b, chainQ[95:64] + c,
                   chainQ[63:32] + d, chainQ[31:0] + e};
endmodule

// File: rtl/pbkdfDatapath.sv
module pbkdfDatapath
  import pbkdfPkg::*;
#(
  parameter int SALT_BYTES = 16,
  parameter int MAX_BLOCKS = 2,
  localparam int DK_BITS = 160 * MAX_BLOCKS,
  localparam int DK_W    = $clog2(DK_BITS + 1),
  localparam int SL_W    = $clog2(SALT_BYTES + 1),
  localparam int BLK_W   = $clog2(MAX_BLOCKS + 1),
  localparam int IDX_W   = (MAX_BLOCKS > 1) ? $clog2(MAX_BLOCKS) : 1
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobe_t             strobe,
  input  logic [159:0]            innerMid,
  input  logic [159:0]            outerMid,
  input  logic [SALT_BYTES*8-1:0] salt,
  input  logic [SL_W-1:0]         saltLen,
  input  logic [31:0]             iterCount,
  input  logic [DK_W-1:0]         dkLen,
  input  logic [DK_BITS-1:0]      targetKey,
  output logic                    coreReady,
  output logic                    lastIter,
  output logic                    lastBlock,
  output logic                    blockOk,
  output logic                    done,
  output logic                    match,
  output logic [BLK_W-1:0]        blocksDone
);
  // Padding for a 20-byte message appended to a 64-byte pad block: 672 bits total.
  localparam logic [63:0] SHORT_LEN = 64'd672;

  logic [159:0]            innerMidQ, outerMidQ, uPrev, acc, innerHash, digest;
  logic [SALT_BYTES*8-1:0] saltQ;
  logic [SL_W-1:0]         saltLenQ;
  logic [31:0]             iterQ, iterLeft, idxWord;
  logic [DK_W-1:0]         dkLenQ, remBits;
  logic [DK_BITS-1:0]      targetQ;
  logic [BLK_W-1:0]        numBlocksQ, blkCnt;
  logic                    firstIter, doneQ, matchQ;
  logic [511:0]            saltBlk, coreBlock;
  logic [159:0]            coreChain, blkMask;
  logic [159:0]            tgtSlice [MAX_BLOCKS];

  assign idxWord = 32'(blkCnt) + 32'd1;

  // First message block of each key block: salt, index, 0x80, zeros, length.
  for (genvar j = 0; j < 56; j++) begin : g_saltByte
    logic [7:0] saltByte, bv;
    logic [6:0] off;
    if (j < SALT_BYTES) begin : g_in
      assign saltByte = saltQ[SALT_BYTES*8-1-8*j -: 8];
    end else begin : g_out
      assign saltByte = 8'h00;
    end
    assign off = 7'(j) - 7'(saltLenQ);
    always_comb begin
      bv = 8'h00;
      if (7'(j) < 7'(saltLenQ))  bv = saltByte;
      else if (off < 7'd4)       bv = 8'(idxWord >> (5'd24 - {off[1:0], 3'b000}));
      else if (off == 7'd4)      bv = 8'h80;
    end
    assign saltBlk[511-8*j -: 8] = bv;
  end
  assign saltBlk[63:0] = 64'((32'd68 + 32'(saltLenQ)) * 32'd8);

  always_comb begin
    if (strobe.selOuter) begin
      coreChain = outerMidQ;
      coreBlock = {innerHash, 8'h80, 280'b0, SHORT_LEN};
    end else begin
      coreChain = innerMidQ;
      coreBlock = firstIter ? saltBlk : {uPrev, 8'h80, 280'b0, SHORT_LEN};
    end
  end

  sha1Core u_core (
    .clk(clk), .rstN(rstN), .go(strobe.coreGo), .chainIn(coreChain),
    .blockIn(coreBlock), .ready(coreReady), .digest(digest)
  );

  for (genvar k = 0; k < MAX_BLOCKS; k++) begin : g_slice
    assign tgtSlice[k] = targetQ[DK_BITS-1-160*k -: 160];
  end

  assign remBits   = dkLenQ - DK_W'(32'd160 * 32'(blkCnt));
  assign blkMask   = (32'(remBits) >= 32'd160) ? {160{1'b1}} : ~({160{1'b1}} >> remBits);
  assign blockOk   = ((acc ^ tgtSlice[blkCnt[IDX_W-1:0]]) & blkMask) == '0;
  assign lastBlock = (32'(blkCnt) + 32'd1) >= 32'(numBlocksQ);
  assign lastIter  = (iterLeft == 32'd1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      innerMidQ <= '0; outerMidQ <= '0; saltQ <= '0; saltLenQ <= '0;
      iterQ <= '0; iterLeft <= '0; dkLenQ <= '0; targetQ <= '0;
      numBlocksQ <= '0; blkCnt <= '0; firstIter <= 1'b1;
      uPrev <= '0; acc <= '0; innerHash <= '0;
      doneQ <= 1'b0; matchQ <= 1'b0;
    end else begin
      doneQ <= 1'b0;
      if (strobe.loadJob) begin
        innerMidQ  <= innerMid;
        outerMidQ  <= outerMid;
        saltQ      <= salt;
        saltLenQ   <= saltLen;
        iterQ      <= (iterCount == '0) ? 32'd1 : iterCount;
        iterLeft   <= (iterCount == '0) ? 32'd1 : iterCount;
        dkLenQ     <= dkLen;
        targetQ    <= targetKey;
        numBlocksQ <= BLK_W'((32'(dkLen) + 32'd159) / 32'd160);
        blkCnt     <= '0;
        firstIter  <= 1'b1;
        matchQ     <= 1'b0;
      end
      if (strobe.takeInner) innerHash <= digest;
      if (strobe.takeOuter) begin
        uPrev     <= digest;
        acc       <= firstIter ? digest : (acc ^ digest);
        iterLeft  <= iterLeft - 32'd1;
        firstIter <= 1'b0;
      end
      if (strobe.closeBlock) begin
        blkCnt    <= blkCnt + 1'b1;
        iterLeft  <= iterQ;
        firstIter <= 1'b1;
      end
      if (strobe.finish) begin
        doneQ  <= 1'b1;
        matchQ <= blockOk;
      end
    end
  end

  assign done       = doneQ;
  assign match      = matchQ;
  assign blocksDone = blkCnt;
endmodule

// File: rtl/pbkdfControl.sv
module pbkdfControl
  import pbkdfPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        coreReady,
  input  logic        lastIter,
  input  logic        lastBlock,
  input  logic        blockOk,
  output ctrlStrobe_t strobe,
  output logic        busy
);
  typedef enum logic [2:0] {IDLE, INNER_GO, INNER_WAIT, OUTER_GO, OUTER_WAIT, CHECK} state_t;
  state_t state, nextState;

  always_comb begin
    strobe    = '0;
    nextState = state;
    unique case (state)
      IDLE: if (start) begin
        strobe.loadJob = 1'b1;
        nextState      = INNER_GO;
      end
      INNER_GO: begin
        strobe.coreGo = 1'b1;
        nextState     = INNER_WAIT;
      end
      INNER_WAIT: if (coreReady) begin
        strobe.takeInner = 1'b1;
        nextState        = OUTER_GO;
      end
      OUTER_GO: begin
        strobe.coreGo   = 1'b1;
        strobe.selOuter = 1'b1;
        nextState       = OUTER_WAIT;
      end
      OUTER_WAIT: if (coreReady) begin
        strobe.takeOuter = 1'b1;
        nextState        = lastIter ? CHECK : INNER_GO;
      end
      CHECK: begin
        strobe.closeBlock = 1'b1;
        if (!blockOk || lastBlock) begin
          strobe.finish = 1'b1;
          nextState     = IDLE;
        end else begin
          nextState = INNER_GO;
        end
      end
      default: nextState = IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= IDLE;
    else       state <= nextState;
  end

  assign busy = (state != IDLE);
endmodule

// File: rtl/pbkdf2Checker.sv
module pbkdf2Checker
  import pbkdfPkg::*;
#(
  parameter int SALT_BYTES = 16,
  parameter int MAX_BLOCKS = 2,
  localparam int DK_BITS = 160 * MAX_BLOCKS,
  localparam int DK_W    = $clog2(DK_BITS + 1),
  localparam int SL_W    = $clog2(SALT_BYTES + 1),
  localparam int BLK_W   = $clog2(MAX_BLOCKS + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [159:0]            innerMid,
  input  logic [159:0]            outerMid,
  input  logic [SALT_BYTES*8-1:0] salt,
  input  logic [SL_W-1:0]         saltLen,
  input  logic [31:0]             iterCount,
  input  logic [DK_W-1:0]         dkLen,
  input  logic [DK_BITS-1:0]      targetKey,
  output logic                    done,
  output logic                    match,
  output logic [BLK_W-1:0]        blocksDone
);
  ctrlStrobe_t strobe;
  logic coreReady, lastIter, lastBlock, blockOk, busy;

  pbkdfControl u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .coreReady(coreReady),
    .lastIter(lastIter), .lastBlock(lastBlock), .blockOk(blockOk),
    .strobe(strobe), .busy(busy)
  );

  pbkdfDatapath #(.SALT_BYTES(SALT_BYTES), .MAX_BLOCKS(MAX_BLOCKS)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .innerMid(innerMid),
    .outerMid(outerMid), .salt(salt), .saltLen(saltLen), .iterCount(iterCount),
    .dkLen(dkLen), .targetKey(targetKey), .coreReady(coreReady),
    .lastIter(lastIter), .lastBlock(lastBlock), .blockOk(blockOk),
    .done(done), .match(match), .blocksDone(blocksDone)
  );
endmodule

// File: rtl/pbkdfCheck.sv
module pbkdfCheck #(
  parameter int MAX_BLOCKS = 2,
  parameter int BLK_W = 2
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             busy,
  input logic             done,
  input logic             match,
  input logic [BLK_W-1:0] blocksDone
);
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6
  done_at_exit_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $fell(busy));

  // R6
  exit_gives_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R7
  job_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(start));

  // R4
  blk_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    32'(blocksDone) <= MAX_BLOCKS);

  // R4
  blk_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$rose(busy) && (blocksDone != $past(blocksDone)))
      |-> (blocksDone == $past(blocksDone) + 1'b1));

  // R6
  match_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (match != $past(match)) |-> (done || $rose(busy)));

  // R6
  match_blocks_chk: assert property (@(posedge clk) disable iff (!rstN)
    match |-> (blocksDone != '0));
endmodule

bind pbkdf2Checker pbkdfCheck #(.MAX_BLOCKS(MAX_BLOCKS), .BLK_W(BLK_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .busy(busy), .done(done),
  .match(match), .blocksDone(blocksDone)
);

// File: tb/test_pbkdf2Checker.sv
module test_pbkdf2Checker;
  localparam int SALT_BYTES = 16;
  localparam int MAX_BLOCKS = 2;
  localparam int DK_BITS = 320;
  localparam logic [159:0] SHA_IV = 160'h67452301EFCDAB8998BADCFE10325476C3D2E1F0;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [159:0] innerMid = '0, outerMid = '0;
  logic [127:0] salt = "saltSALTsaltSALT";
  logic [4:0]   saltLen = '0;
  logic [31:0]  iterCount = '0;
  logic [8:0]   dkLen = '0;
  logic [319:0] targetKey = '0;
  logic done, match;
  logic [1:0] blocksDone;

  int checks = 0, fails = 0, cycles = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cycles++;

  pbkdf2Checker #(.SALT_BYTES(SALT_BYTES), .MAX_BLOCKS(MAX_BLOCKS)) i_pbkdf2Checker (
    .clk(clk), .rstN(rstN), .start(start), .innerMid(innerMid), .outerMid(outerMid),
    .salt(salt), .saltLen(saltLen), .iterCount(iterCount), .dkLen(dkLen),
    .targetKey(targetKey), .done(done), .match(match), .blocksDone(blocksDone)
  );

  // Reference SHA1 compression, written straight from the algorithm.
  function automatic logic [159:0] sha1c(input logic [159:0] h, input logic [511:0] m);
    logic [31:0] w [80];
    logic [31:0] a, b, c, d, e, f, k, t;
    for (int i = 0; i < 16; i++) w[i] = m[511-32*i -: 32];
    for (int i = 16; i < 80; i++) begin
      t = w[i-3] ^ w[i-8] ^ w[i-14] ^ w[i-16];
      w[i] = {t[30:0], t[31]};
    end
    {a, b, c, d, e} = h;
    for (int i = 0; i < 80; i++) begin
      if (i < 20)      begin f = (b & c) | (~b & d);          k = 32'h5A827999; end
      else if (i < 40) begin f = b ^ c ^ d;                   k = 32'h6ED9EBA1; end
      else if (i < 60) begin f = (b & c) | (b & d) | (c & d); k = 32'h8F1BBCDC; end
      else             begin f = b ^ c ^ d;                   k = 32'hCA62C1D6; end
      t = {a[26:0], a[31:27]} + f + e + k + w[i];
      e = d; d = c; c = {b[1:0], b[31:2]}; b = a; a = t;
    end
    return {h[159:128] + a, h[127:96] + b, h[95:64] + c, h[63:32] + d, h[31:0] + e};
  endfunction

  function automatic logic [159:0] hmacShort(input logic [159:0] im, input logic [159:0] om,
                                             input logic [159:0] msg);
    logic [159:0] inner;
    inner = sha1c(im, {msg, 8'h80, 280'b0, 64'd672});
    return sha1c(om, {inner, 8'h80, 280'b0, 64'd672});
  endfunction

  function automatic logic [159:0] keyBlock(input logic [159:0] im, input logic [159:0] om,
                                            input logic [127:0] s, input int sl,
                                            input int c, input int idx);
    logic [7:0] by [64];
    logic [511:0] blk;
    logic [159:0] u, x;
    logic [31:0] iw;
    logic [63:0] lenBits;
    iw = 32'(idx);
    lenBits = 64'((64 + sl + 4) * 8);
    for (int j = 0; j < 64; j++) by[j] = 8'h00;
    for (int j = 0; j < sl; j++) by[j] = s[127-8*j -: 8];
    for (int j = 0; j < 4; j++) by[sl+j] = iw[31-8*j -: 8];
    by[sl+4] = 8'h80;
    for (int j = 0; j < 8; j++) by[56+j] = lenBits[63-8*j -: 8];
    for (int j = 0; j < 64; j++) blk[511-8*j -: 8] = by[j];
    u = sha1c(om, {sha1c(im, blk), 8'h80, 280'b0, 64'd672});
    x = u;
    for (int i = 1; i < c; i++) begin
      u = hmacShort(im, om, u);
      x = x ^ u;
    end
    return x;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [159:0] act, input logic [159:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic string tagName(input int t);
    case (t)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      default: return "R5";
    endcase
  endfunction

  task automatic launch(input int c, input int dk, input int sl, input logic [319:0] tgt);
    @(negedge clk);
    iterCount = 32'(c);
    dkLen = 9'(dk);
    saltLen = 5'(sl);
    targetKey = tgt;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitDone(output bit seen);
    int guard = 0;
    seen = 1'b0;
    while (!done && guard < 60000) begin
      @(negedge clk);
      guard++;
    end
    if (done) seen = 1'b1;
    else check(1'b0, "R6", "watchdog waiting for done", 0, 1);
  endtask

  typedef struct packed {
    int c;
    int dk;
    int sl;
    int flip;       // derived bit position to invert, -1 for none
    int expMatch;
    int expBlocks;
    int tag;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{c: 1,  dk: 160, sl: 4,  flip: -1,  expMatch: 1, expBlocks: 1, tag: 1},
    '{c: 2,  dk: 320, sl: 4,  flip: -1,  expMatch: 1, expBlocks: 2, tag: 2},
    '{c: 3,  dk: 256, sl: 4,  flip: 17,  expMatch: 0, expBlocks: 1, tag: 4},
    '{c: 3,  dk: 256, sl: 4,  flip: 200, expMatch: 0, expBlocks: 2, tag: 4},
    '{c: 3,  dk: 256, sl: 4,  flip: 300, expMatch: 1, expBlocks: 2, tag: 5},
    '{c: 0,  dk: 160, sl: 4,  flip: -1,  expMatch: 1, expBlocks: 1, tag: 3},
    '{c: 5,  dk: 100, sl: 7,  flip: 120, expMatch: 1, expBlocks: 1, tag: 5},
    '{c: 2,  dk: 160, sl: 0,  flip: -1,  expMatch: 1, expBlocks: 1, tag: 1},
    '{c: 2,  dk: 200, sl: 16, flip: 170, expMatch: 0, expBlocks: 2, tag: 1},
    '{c: 40, dk: 320, sl: 11, flip: -1,  expMatch: 1, expBlocks: 2, tag: 2}
  };

  initial begin : watchdog
    wait (cycles >= 190000);
    check(1'b0, "R6", "global watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin : main
    logic [511:0] keyPad;
    logic [159:0] k1, k2;
    logic [319:0] full;
    bit seen;
    int extra;

    keyPad   = {"password", 448'b0};
    innerMid = sha1c(SHA_IV, keyPad ^ {64{8'h36}});
    outerMid = sha1c(SHA_IV, keyPad ^ {64{8'h5C}});

    // R8: reset state
    repeat (3) @(negedge clk);
    check(done == 1'b0, "R8", "done in reset", 160'(done), 0);
    check(match == 1'b0, "R8", "match in reset", 160'(match), 0);
    check(blocksDone == 2'd0, "R8", "blocksDone in reset", 160'(blocksDone), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(done == 1'b0 && blocksDone == 2'd0, "R8", "idle after reset", 160'(done), 0);

    // R1 R2: published known answers for one and two iterations
    launch(1, 160, 4, {160'h0c60c80f961f0e71f3a9b524af6012062fe037a6, 160'h0});
    waitDone(seen);
    check(match == 1'b1, "R1", "known answer c=1", 160'(match), 1);
    check(blocksDone == 2'd1, "R1", "blocks c=1", 160'(blocksDone), 1);
    launch(2, 160, 4, {160'hea6c014dc72d6f8ccd1ed92ace1d41f0d8de8957, 160'h0});
    waitDone(seen);
    check(match == 1'b1, "R2", "known answer c=2", 160'(match), 1);
    check(blocksDone == 2'd1, "R2", "blocks c=2", 160'(blocksDone), 1);

    // Table of vectors
    for (int v = 0; v < 10; v++) begin
      int ce;
      ce = (VECS[v].c == 0) ? 1 : VECS[v].c;
      k1 = keyBlock(innerMid, outerMid, salt, VECS[v].sl, ce, 1);
      k2 = keyBlock(innerMid, outerMid, salt, VECS[v].sl, ce, 2);
      full = {k1, k2};
      if (VECS[v].flip >= 0) full[319 - VECS[v].flip] = ~full[319 - VECS[v].flip];
      launch(VECS[v].c, VECS[v].dk, VECS[v].sl, full);
      waitDone(seen);
      check(32'(match) == VECS[v].expMatch, tagName(VECS[v].tag),
            $sformatf("vector %0d match", v), 160'(match), 160'(VECS[v].expMatch));
      check(32'(blocksDone) == VECS[v].expBlocks, "R4",
            $sformatf("vector %0d blocksDone", v), 160'(blocksDone), 160'(VECS[v].expBlocks));
    end

    // R6: single-cycle done, results held afterwards
    k1 = keyBlock(innerMid, outerMid, salt, 4, 1, 1);
    launch(1, 160, 4, {k1, 160'h0});
    waitDone(seen);
    @(negedge clk);
    check(done == 1'b0, "R6", "done lasts one cycle", 160'(done), 0);
    repeat (6) @(negedge clk);
    check(match == 1'b1, "R6", "match held", 160'(match), 1);
    check(blocksDone == 2'd1, "R6", "blocksDone held", 160'(blocksDone), 1);

    // R7: start while busy is ignored
    k1 = keyBlock(innerMid, outerMid, salt, 4, 3, 1);
    launch(3, 160, 4, {k1 ^ 160'h1, 160'h0});
    repeat (30) @(negedge clk);
    iterCount = 32'd1;
    targetKey = {keyBlock(innerMid, outerMid, salt, 4, 1, 1), 160'h0};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waitDone(seen);
    check(match == 1'b0, "R7", "first job result kept", 160'(match), 0);
    check(blocksDone == 2'd1, "R7", "first job blocks kept", 160'(blocksDone), 1);
    extra = 0;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (done) extra++;
    end
    check(extra == 0, "R7", "no second done", 160'(extra), 0);
    check(match == 1'b0, "R7", "match unchanged after ignored start", 160'(match), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule